// File: doc/BRIEF.md
# ADC Power Mode Sequencer

This block drives the two power-control pins of a dual-channel ADC from a requested operating mode, and reports when the converter's output data can be trusted again. A mode request is sampled on every clock. When it differs from the mode currently applied, the pins take the new encoding on that same edge. If the new mode is a low-power one, data-valid drops at once. If the new mode is normal operation, a wake-up wait starts, and its length depends on the low-power mode being left.

The wait lengths are counted in clock cycles and are derived from parameters for the clock frequency and the wake-up times. With the default 250 MHz clock, leaving shutdown takes 5000 cycles (20 µs), leaving standby takes 1350 cycles (5.4 µs), and leaving idle takes a 4-cycle output-enable margin. Idle needs only this margin because the converter core keeps running in that mode. A new request that arrives during a wait discards that wait and restarts the sequence from the newly requested mode. The busy flag is high for exactly the cycles of a running wait.

Top module: `adc_pwr_seq`

## Requirements
- R1: While the asynchronous reset is low, and after its release until a new request is seen, the applied mode is shutdown: both pins are 0, busy is 0 and data-valid is 0.
- R2: Mode codes on `mode_req_i` are 0 = normal, 1 = idle, 2 = standby and 3 = shutdown. The pins (`pwr_a_o`, `pwr_b_o`) are normal 1,1; idle 1,0; standby 0,1; shutdown 0,0. They take the new values on the first clock edge that samples a changed request.
- R3: After a move from shutdown to normal, data-valid rises 5000 cycles (defaults) after the edge that switched the pins to normal.
- R4: After a move from standby to normal, data-valid rises 1350 cycles (defaults) after that edge.
- R5: After a move from idle to normal, data-valid rises OE_MARGIN_CYC = 4 cycles after that edge.
- R6: Busy is 1 on exactly the cycles between the edge that starts a wait and the edge that raises data-valid, and is 0 at all other times.
- R7: A request for any low-power mode clears data-valid and busy on the same edge that changes the pins.
- R8: A request that arrives during a wait restarts the sequence. The next wait to normal uses the duration of the most recently requested low-power mode.
- R9: Data-valid is 1 only while both pins are 1 and busy is 0.
- R10: Holding the same request has no effect: in normal mode with data valid, data-valid stays 1 and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_req_i | input | 2 | Requested mode code |
| pwr_a_o | output | 1 | First power-control pin |
| pwr_b_o | output | 1 | Second power-control pin |
| busy_o | output | 1 | Wake-up wait in progress |
| data_valid_o | output | 1 | Converter output data is valid |

## Verification
The assertions check the invariants on every cycle:
- data-valid appears only with both pins high and no wait running;
- busy appears only in normal mode;
- a finished wait always ends in data-valid;
- no wait runs longer than the longest wake-up time;
- the pins follow the previous cycle's request in normal and shutdown.

Only the bench scenarios can show the exact wait length for each low-power mode being left, the restart rules when a request interrupts a wait, and the asynchronous reset taking effect in the middle of a wait.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'd0,
    MODE_IDLE     = 2'd1,
    MODE_STANDBY  = 2'd2,
    MODE_SHUTDOWN = 2'd3
  } mode_e;

  typedef struct packed {
    logic a;
    logic b;
  } pins_t;

endpackage

// File: rtl/adc_pwr_enc.sv
module adc_pwr_enc
  import adc_pwr_pkg::*;
(
  input  mode_e mode_i,
  output pins_t pins_o
);

  always_comb begin
    unique case (mode_i)
      MODE_NORMAL:   pins_o = '{a: 1'b1, b: 1'b1};
      MODE_IDLE:     pins_o = '{a: 1'b1, b: 1'b0};
      MODE_STANDBY:  pins_o = '{a: 1'b0, b: 1'b1};
      default:       pins_o = '{a: 1'b0, b: 1'b0};
    endcase
  end

endmodule

// File: rtl/adc_pwr_wait_sel.sv
module adc_pwr_wait_sel
  import adc_pwr_pkg::*;
#(
  parameter int unsigned CNT_W  = 13,
  parameter int unsigned SD_CYC = 5000,
  parameter int unsigned SB_CYC = 1350,
  parameter int unsigned OE_CYC = 4
) (
  input  mode_e             from_i,
  output logic [CNT_W-1:0]  cycles_o
);

  always_comb begin
    unique case (from_i)
      MODE_SHUTDOWN: cycles_o = CNT_W'(SD_CYC);
      MODE_STANDBY:  cycles_o = CNT_W'(SB_CYC);
      MODE_IDLE:     cycles_o = CNT_W'(OE_CYC);
      default:       cycles_o = CNT_W'(1);
    endcase
  end

endmodule

// File: rtl/adc_pwr_timer.sv
module adc_pwr_timer #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             busy_o,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= val_i;
    else if (clr_i)   cnt_q <= '0;
    else if (busy_o)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o   = (cnt_q != '0);
  // last counted cycle, unless overridden by a new request
  assign expire_o = (cnt_q == CNT_W'(1)) && !load_i && !clr_i;

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter int unsigned CLK_MHZ       = 250,
  parameter int unsigned SD_WAKE_NS    = 20000,
  parameter int unsigned SB_WAKE_NS    = 5400,
  parameter int unsigned OE_MARGIN_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_req_i,
  output logic       pwr_a_o,
  output logic       pwr_b_o,
  output logic       busy_o,
  output logic       data_valid_o
);

  localparam int unsigned SD_CYC   = (CLK_MHZ * SD_WAKE_NS + 999) / 1000;
  localparam int unsigned SB_CYC   = (CLK_MHZ * SB_WAKE_NS + 999) / 1000;
  localparam int unsigned MAX_AB   = (SD_CYC > SB_CYC) ? SD_CYC : SB_CYC;
  localparam int unsigned WAIT_MAX = (MAX_AB > OE_MARGIN_CYC) ? MAX_AB : OE_MARGIN_CYC;
  localparam int unsigned CNT_W    = $clog2(WAIT_MAX + 1);

  mode_e            req;
  mode_e            tgt_q;
  pins_t            pins_d, pins_q;
  logic             req_new, load, clr, expire;
  logic [CNT_W-1:0] wait_cyc;
  logic             valid_q;

  assign req     = mode_e'(mode_req_i);
  assign req_new = (req != tgt_q);
  assign load    = req_new && (req == MODE_NORMAL);
  assign clr     = req_new && (req != MODE_NORMAL);

  adc_pwr_enc u_enc (
    .mode_i (req),
    .pins_o (pins_d)
  );

  adc_pwr_wait_sel #(
    .CNT_W  (CNT_W),
    .SD_CYC (SD_CYC),
    .SB_CYC (SB_CYC),
    .OE_CYC (OE_MARGIN_CYC)
  ) u_sel (
    .from_i   (tgt_q),
    .cycles_o (wait_cyc)
  );

  adc_pwr_timer #(
    .CNT_W (CNT_W)
  ) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .clr_i    (clr),
    .val_i    (wait_cyc),
    .busy_o   (busy_o),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q   <= MODE_SHUTDOWN;
      pins_q  <= '{a: 1'b0, b: 1'b0};
      valid_q <= 1'b0;
    end else if (req_new) begin
      tgt_q   <= req;
      pins_q  <= pins_d;
      valid_q <= 1'b0;
    end else if (expire) begin
      valid_q <= 1'b1;
    end
  end

  assign pwr_a_o      = pins_q.a;
  assign pwr_b_o      = pins_q.b;
  assign data_valid_o = valid_q;

endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk #(
  parameter int unsigned CLK_MHZ       = 250,
  parameter int unsigned SD_WAKE_NS    = 20000,
  parameter int unsigned SB_WAKE_NS    = 5400,
  parameter int unsigned OE_MARGIN_CYC = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_req_i,
  input logic       pwr_a_o,
  input logic       pwr_b_o,
  input logic       busy_o,
  input logic       data_valid_o
);

  localparam int unsigned SD_CYC   = (CLK_MHZ * SD_WAKE_NS + 999) / 1000;
  localparam int unsigned SB_CYC   = (CLK_MHZ * SB_WAKE_NS + 999) / 1000;
  localparam int unsigned MAX_AB   = (SD_CYC > SB_CYC) ? SD_CYC : SB_CYC;
  localparam int unsigned WAIT_MAX = (MAX_AB > OE_MARGIN_CYC) ? MAX_AB : OE_MARGIN_CYC;

  int unsigned busy_run;
  logic        armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_run <= 0;
      armed    <= 1'b0;
    end else begin
      busy_run <= busy_o ? busy_run + 1 : 0;
      armed    <= 1'b1;
    end
  end

  AST_VALID_NEEDS_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> (pwr_a_o && pwr_b_o && !busy_o)); // R9

  AST_BUSY_ONLY_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (pwr_a_o && pwr_b_o)); // R6

  AST_LOWPWR_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pwr_a_o && pwr_b_o) |-> (!data_valid_o && !busy_o)); // R7

  AST_WAIT_ENDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && pwr_a_o && pwr_b_o) |-> data_valid_o); // R6

  AST_WAIT_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_run <= WAIT_MAX); // R3

  AST_PINS_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(mode_req_i) == 2'd0) |-> (pwr_a_o && pwr_b_o)); // R2

  AST_PINS_SHUTDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(mode_req_i) == 2'd3) |-> (!pwr_a_o && !pwr_b_o)); // R2

endmodule

bind adc_pwr_seq adc_pwr_seq_chk #(
  .CLK_MHZ       (CLK_MHZ),
  .SD_WAKE_NS    (SD_WAKE_NS),
  .SB_WAKE_NS    (SB_WAKE_NS),
  .OE_MARGIN_CYC (OE_MARGIN_CYC)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_req_i   (mode_req_i),
  .pwr_a_o      (pwr_a_o),
  .pwr_b_o      (pwr_b_o),
  .busy_o       (busy_o),
  .data_valid_o (data_valid_o)
);

// File: tb/sim_adc_pwr_seq.sv
`timescale 1ns/1ps
module sim_adc_pwr_seq;

  localparam int SD_W = 5000;
  localparam int SB_W = 1350;
  localparam int OE_W = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] req = 2'd3;
  logic       pa, pb, busy, valid;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  adc_pwr_seq u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .mode_req_i   (req),
    .pwr_a_o      (pa),
    .pwr_b_o      (pb),
    .busy_o       (busy),
    .data_valid_o (valid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_mode = 3;
  int m_left = 0;
  int m_valid = 0;

  function automatic int wake_of(input int from);
    if (from == 3) return SD_W;
    if (from == 2) return SB_W;
    return OE_W;
  endfunction

  function automatic int pins_of(input int m);
    case (m)
      0: return 3;
      1: return 2;
      2: return 1;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 3; m_left = 0; m_valid = 0;
    end else if (int'(req) != m_mode) begin
      m_left  = (req == 2'd0) ? wake_of(m_mode) : 0;
      m_mode  = int'(req);
      m_valid = 0;
    end else if (m_left > 0) begin
      m_left--;
      if (m_left == 0) m_valid = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 pins", int'({pa, pb}), pins_of(m_mode));
      chk("R6 busy", int'(busy), int'(m_left > 0));
      chk("R3/R4/R5/R8 valid", int'(valid), m_valid);
    end
  end

  task automatic measure(input int exp_n, input string tag);
    int n = 0;
    req = 2'd0;
    do begin
      @(negedge clk);
      n++;
    end while (!valid && n < 8000);
    chk(tag, n, exp_n);
  endtask

  task automatic go(input logic [1:0] m, input int cyc);
    req = m;
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pins in reset", int'({pa, pb}), 0);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 valid in reset", int'(valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 pins after reset", int'({pa, pb}), 0);
    chk("R1 valid after reset", int'(valid), 0);

    go(2'd1, 1);
    chk("R2 idle pins", int'({pa, pb}), 2);
    chk("R7 idle valid", int'(valid), 0);
    measure(OE_W + 1, "R5 idle exit");

    go(2'd2, 10);
    chk("R2 standby pins", int'({pa, pb}), 1);
    measure(SB_W + 1, "R4 standby exit");

    go(2'd0, 50);
    chk("R10 hold valid", int'(valid), 1);
    chk("R10 hold busy", int'(busy), 0);

    go(2'd3, 1);
    chk("R7 shutdown valid", int'(valid), 0);
    chk("R7 shutdown busy", int'(busy), 0);
    chk("R2 shutdown pins", int'({pa, pb}), 0);
    measure(SD_W + 1, "R3 shutdown exit");

    // restart: shutdown wake interrupted by standby
    go(2'd3, 1);
    go(2'd0, 100);
    chk("R6 busy mid wait", int'(busy), 1);
    go(2'd2, 1);
    chk("R8 busy cleared", int'(busy), 0);
    chk("R8 valid cleared", int'(valid), 0);
    repeat (2) @(negedge clk);
    measure(SB_W + 1, "R8 restart from standby");

    // idle margin interrupted by shutdown
    go(2'd1, 1);
    go(2'd0, 2);
    go(2'd3, 1);
    measure(SD_W + 1, "R8 restart from shutdown");

    // shutdown then standby before normal
    go(2'd3, 1);
    go(2'd2, 1);
    measure(SB_W + 1, "R8 latest low-power mode");

    // async reset mid wait
    go(2'd3, 1);
    go(2'd0, 20);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 async pins", int'({pa, pb}), 0);
    chk("R1 async busy", int'(busy), 0);
    chk("R1 async valid", int'(valid), 0);
    req = 2'd3;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 post reset valid", int'(valid), 0);
    measure(SD_W + 1, "R3 after reset");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog R1..R10 act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule